// File: doc/BRIEF.md
# Multiply-Add Unit with Short Signed Shortcut

This unit multiplies two 64-bit operands, adds a 128-bit addend to the 128-bit product and can hand back the bitwise complement of that sum. A requester raises `start_i` for one cycle with the operands, the signed/unsigned mode, the addend, the complement control and a flag that says only the low 64 bits of the result matter. Each request is answered with a one-cycle `done_o` pulse and a 128-bit `result_o`.

Most requests go through a fixed three-stage pipeline, which can take a new request every cycle. A plain signed multiply whose operands both fit in 16 signed bits, and whose caller wants only the low half, is instead answered in the cycle it is issued. The answer comes from a small combinational 16x16 multiplier. To negate a product, the caller sets the complement control and an addend of all ones. An overflow flag for the low half follows each result one cycle later.

Top module: `mac_short_unit`

## Requirements
- R1: A request with `start_i`=1, `signed_i`=1, `low_only_i`=1, `invert_i`=0, `addend_i`=0 and both operands in -32768..32767 takes the short path. `done_o` is 1 in that same cycle, and `result_o` is the 128-bit sign extension of the product.
- R2: Every other request raises `done_o` exactly 3 cycles after its start cycle. For the unit to issue it, `result_o` carries the low 128 bits of (extended A times extended B) plus `addend_i`.
- R3: With `invert_i`=1 the result is the bitwise complement of product plus addend. An addend of all ones therefore gives the two's-complement negation of the product.
- R4: With `signed_i`=0 the operands are zero-extended and the short path is never used. With `signed_i`=1 they are sign-extended.
- R5: `ovf_o` is valid in the cycle after each `done_o` pulse and is 0 in every other cycle. For a signed low-only request it is 1 when the upper 64 result bits are not all copies of result bit 63. For an unsigned low-only request it is 1 when the upper 64 bits are non-zero. It is 0 for full-width requests and for short-path results.
- R6: The full path accepts a start every cycle and returns results in issue order, one per cycle.
- R7: A request that would qualify for the short path goes to the full path if a full-path result retires in its cycle. In that case it completes 3 cycles later.
- R8: While reset is asserted and right after it, `done_o` and `ovf_o` are 0.
- R9: A request with `low_only_i`=0 never takes the short path, even with small operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| signed_i | input | 1 | 1 = signed operands, 0 = unsigned |
| low_only_i | input | 1 | 1 = only the low 64 result bits are needed |
| invert_i | input | 1 | 1 = complement product plus addend |
| op_a_i | input | 64 | Multiplicand |
| op_b_i | input | 64 | Multiplier |
| addend_i | input | 128 | Value added to the product |
| done_o | output | 1 | Result valid strobe |
| result_o | output | 128 | Result |
| ovf_o | output | 1 | Low-half overflow, one cycle after `done_o` |

## Verification
The bench probes the operand range edges (-32768 and 32767 take the shortcut, -32769 and 32768 do not); a wrong range test shows up as a same-cycle `done_o` where none is due, or the reverse. It uses small unsigned operands and small full-width requests to catch a shortcut that ignores the mode or the low-only flag. It checks that the negation recipe gives the exact two's complement, so a wrongly ordered complement and add is caught. A shortcut request that collides with a retiring pipeline result must come out three cycles later rather than be lost or overwrite the older result. Overflow is checked on its one-cycle delay, so a flag on the wrong cycle or with the wrong rule per mode fails.

// File: rtl/mac_short_pkg.sv
package mac_short_pkg;
  parameter int unsigned OP_W    = 64;
  parameter int unsigned SHORT_W = 16;
  localparam int unsigned RES_W  = 2 * OP_W;
  localparam int unsigned EXT_W  = OP_W + 1;

  typedef struct packed {
    logic             sgn;
    logic             low;
    logic             inv;
    logic [RES_W-1:0] add;
  } req_ctl_t;
endpackage

// File: rtl/mac_short_range.sv
module mac_short_range #(
  parameter int unsigned OP_W    = 64,
  parameter int unsigned SHORT_W = 16
) (
  input  logic [OP_W-1:0] val_i,
  output logic            fits_o
);
  localparam int unsigned TOP = OP_W - SHORT_W + 1;
  logic [TOP-1:0] hi;
  assign hi     = val_i[OP_W-1:SHORT_W-1];
  assign fits_o = (&hi) | ~(|hi);
endmodule

// File: rtl/mac_short_mul.sv
module mac_short_mul #(
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned RES_W   = 128
) (
  input  logic [SHORT_W-1:0] a_i,
  input  logic [SHORT_W-1:0] b_i,
  output logic [RES_W-1:0]   prod_o
);
  localparam int unsigned P_W = 2 * SHORT_W;
  logic signed [P_W-1:0] p;
  always_comb begin
    p      = $signed(a_i) * $signed(b_i);
    prod_o = {{(RES_W-P_W){p[P_W-1]}}, p};
  end
endmodule

// File: rtl/mac_full_pipe.sv
module mac_full_pipe
  import mac_short_pkg::*;
#(
  parameter int unsigned W = OP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld_i,
  input  req_ctl_t         in_ctl_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             out_vld_o,
  output logic [2*W-1:0]   out_res_o,
  output logic             out_ovf_o
);
  localparam int unsigned RW = 2 * W;
  localparam int unsigned XW = W + 1;

  logic            v1_q, v2_q, v3_q;
  req_ctl_t        c1_q, c2_q;
  logic            s3_sgn_q, s3_low_q;
  logic [XW-1:0]   a1_q, b1_q;
  logic [RW-1:0]   p2_q, r3_q;

  logic [XW-1:0]   a1_d, b1_d;
  logic [RW-1:0]   p2_d, r3_d, sum;
  logic signed [2*XW-1:0] full_p;

  always_comb begin
    a1_d   = in_ctl_i.sgn ? {a_i[W-1], a_i} : {1'b0, a_i};
    b1_d   = in_ctl_i.sgn ? {b_i[W-1], b_i} : {1'b0, b_i};
    full_p = $signed(a1_q) * $signed(b1_q);
    p2_d   = full_p[RW-1:0];
    sum    = p2_q + c2_q.add;
    r3_d   = c2_q.inv ? ~sum : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_vld_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld_i) begin
      a1_q <= a1_d;
      b1_q <= b1_d;
      c1_q <= in_ctl_i;
    end
    if (v1_q) begin
      p2_q <= p2_d;
      c2_q <= c1_q;
    end
    if (v2_q) begin
      r3_q     <= r3_d;
      s3_sgn_q <= c2_q.sgn;
      s3_low_q <= c2_q.low;
    end
  end

  assign out_vld_o = v3_q;
  assign out_res_o = r3_q;
  always_comb begin
    if (!s3_low_q)     out_ovf_o = 1'b0;
    else if (s3_sgn_q) out_ovf_o = (r3_q[RW-1:W] != {W{r3_q[W-1]}});
    else               out_ovf_o = |r3_q[RW-1:W];
  end

  // R6: a start accepted now must retire three cycles later
  a_r6_pipe_depth: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i |-> ##3 out_vld_o);
endmodule

// File: rtl/mac_short_unit.sv
module mac_short_unit
  import mac_short_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic               low_only_i,
  input  logic               invert_i,
  input  logic [OP_W-1:0]    op_a_i,
  input  logic [OP_W-1:0]    op_b_i,
  input  logic [RES_W-1:0]   addend_i,
  output logic               done_o,
  output logic [RES_W-1:0]   result_o,
  output logic               ovf_o
);
  logic             a_fits, b_fits, short_ok, short_hit;
  logic             pipe_vld, pipe_ovf, ovf_q, ovf_d;
  logic [RES_W-1:0] short_res, pipe_res;
  req_ctl_t         ctl;

  mac_short_range #(.OP_W(OP_W), .SHORT_W(SHORT_W)) u_rng_a (.val_i(op_a_i), .fits_o(a_fits));
  mac_short_range #(.OP_W(OP_W), .SHORT_W(SHORT_W)) u_rng_b (.val_i(op_b_i), .fits_o(b_fits));

  mac_short_mul #(.SHORT_W(SHORT_W), .RES_W(RES_W)) u_short (
    .a_i(op_a_i[SHORT_W-1:0]), .b_i(op_b_i[SHORT_W-1:0]), .prod_o(short_res));

  always_comb begin
    ctl.sgn   = signed_i;
    ctl.low   = low_only_i;
    ctl.inv   = invert_i;
    ctl.add   = addend_i;
    short_ok  = signed_i & low_only_i & ~invert_i & ~(|addend_i) & a_fits & b_fits;
    short_hit = start_i & short_ok & ~pipe_vld;
  end

  mac_full_pipe #(.W(OP_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld_i(start_i & ~short_hit), .in_ctl_i(ctl),
    .a_i(op_a_i), .b_i(op_b_i),
    .out_vld_o(pipe_vld), .out_res_o(pipe_res), .out_ovf_o(pipe_ovf));

  always_comb begin
    done_o   = short_hit | pipe_vld;
    result_o = short_hit ? short_res : pipe_res;
    ovf_d    = pipe_vld & pipe_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end
  assign ovf_o = ovf_q;

  // R1: shortcut only for operands inside the signed 16-bit range
  a_r1_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    short_hit |-> ($signed(op_a_i) >= -32768 && $signed(op_a_i) <= 32767 &&
                   $signed(op_b_i) >= -32768 && $signed(op_b_i) <= 32767));
  // R2: a request that skips the shortcut completes three cycles later
  a_r2_full_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !short_hit) |-> ##3 done_o);
  // R5: overflow only in the cycle after a completion
  a_r5_ovf_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_o) |-> !ovf_o);
  // R7: shortcut and pipeline never retire in the same cycle
  a_r7_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({short_hit, pipe_vld}));
  // R4: unsigned requests never use the shortcut
  a_r4_unsigned_full: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !signed_i) |-> !short_hit);
endmodule

// File: tb/mac_short_unit_tb.sv
module mac_short_unit_tb_top;
  typedef struct packed {
    logic [63:0]  a;
    logic [63:0]  b;
    logic [127:0] add;
    logic         inv;
    logic         sgn;
    logic         low;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{64'd7, 64'd9, 128'd0, 1'b0, 1'b1, 1'b1},
    '{64'hFFFF_FFFF_FFFF_8000, 64'd32767, 128'd0, 1'b0, 1'b1, 1'b1},
    '{64'd32768, 64'd3, 128'd0, 1'b0, 1'b1, 1'b1},
    '{64'hFFFF_FFFF_FFFF_7FFF, 64'd2, 128'd0, 1'b0, 1'b1, 1'b1},
    '{64'd5, 64'd6, 128'd0, 1'b0, 1'b0, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 128'd0, 1'b0, 1'b0, 1'b0},
    '{64'h0000_0100_0000_0000, 64'h0000_0000_4000_0000, 128'd0, 1'b0, 1'b1, 1'b1},
    '{64'd100, 64'd200, 128'd55, 1'b0, 1'b1, 1'b1},
    '{64'd12, 64'd13, {128{1'b1}}, 1'b1, 1'b1, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFD, 64'd7, 128'd0, 1'b0, 1'b1, 1'b0}
  };

  logic clk, rst_n, start_i, signed_i, low_only_i, invert_i;
  logic [63:0] op_a_i, op_b_i;
  logic [127:0] addend_i, result_o;
  logic done_o, ovf_o;
  int checks = 0, errors = 0;

  mac_short_unit dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [127:0] ext(logic [63:0] x, logic s);
    return s ? {{64{x[63]}}, x} : {64'd0, x};
  endfunction
  function automatic logic [127:0] model(vec_t v);
    logic [127:0] s;
    s = ext(v.a, v.sgn) * ext(v.b, v.sgn) + v.add;
    return v.inv ? ~s : s;
  endfunction
  function automatic logic model_ovf(vec_t v);
    logic [127:0] r;
    r = model(v);
    if (!v.low) return 1'b0;
    if (v.sgn)  return r[127:64] != {64{r[63]}};
    return |r[127:64];
  endfunction
  function automatic logic fits(logic [63:0] x);
    return ($signed(x) >= -32768) && ($signed(x) <= 32767);
  endfunction
  function automatic logic eligible(vec_t v);
    return v.sgn && v.low && !v.inv && v.add == 0 && fits(v.a) && fits(v.b);
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    op_a_i = v.a; op_b_i = v.b; addend_i = v.add;
    invert_i = v.inv; signed_i = v.sgn; low_only_i = v.low; start_i = 1'b1;
  endtask

  task automatic run_one(vec_t v);
    @(negedge clk); drive(v); #1;
    if (eligible(v)) begin
      check("R1 short done", done_o, 1);
      check("R1 short result", result_o, model(v));
      @(negedge clk); start_i = 1'b0; #1;
      check("R5 ovf after short", ovf_o, 0);
    end else begin
      check("R2 no early done", done_o, 0);
      @(negedge clk); start_i = 1'b0;
      @(negedge clk); #1;
      check("R2 not yet done", done_o, 0);
      @(negedge clk); #1;
      check("R2 done at 3", done_o, 1);
      check("R2 R3 R4 R9 result", result_o, model(v));
      @(negedge clk); #1;
      check("R5 ovf", ovf_o, model_ovf(v));
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t p, q, r, neg;
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; low_only_i = 1'b0; invert_i = 1'b0;
    op_a_i = '0; op_b_i = '0; addend_i = '0;
    repeat (3) @(negedge clk);
    check("R8 reset done", done_o, 0);
    check("R8 reset ovf", ovf_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset done", done_o, 0);

    for (int i = 0; i < NV; i++) run_one(VEC[i]);

    // R3 negation equals two's complement of the product
    neg = VEC[8];
    check("R3 negate", model(neg), -(128'd12 * 128'd13));

    // R9 small operands with full-width request must wait
    r = '{64'd3, 64'd4, 128'd0, 1'b0, 1'b1, 1'b0};
    @(negedge clk); drive(r); #1;
    check("R9 no shortcut", done_o, 0);
    @(negedge clk); start_i = 1'b0;
    repeat (2) @(negedge clk);

    // R6 back-to-back starts
    p = '{64'd1000000, 64'd3, 128'd1, 1'b0, 1'b0, 1'b0};
    q = '{64'd70000, 64'd70000, 128'd0, 1'b0, 1'b1, 1'b1};
    r = '{64'd9, 64'd9, 128'd0, 1'b0, 1'b0, 1'b1};
    @(negedge clk); drive(p);
    @(negedge clk); drive(q);
    @(negedge clk); drive(r);
    @(negedge clk); start_i = 1'b0; #1;
    check("R6 first", result_o, model(p));
    @(negedge clk); #1;
    check("R6 second", result_o, model(q));
    @(negedge clk); #1;
    check("R6 third", result_o, model(r));
    check("R6 third done", done_o, 1);
    repeat (2) @(negedge clk);

    // R7 shortcut request collides with a retiring pipeline result
    p = '{64'd40000, 64'd5, 128'd0, 1'b0, 1'b1, 1'b1};
    q = '{64'd11, 64'd12, 128'd0, 1'b0, 1'b1, 1'b1};
    @(negedge clk); drive(p);
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    @(negedge clk); drive(q); #1;
    check("R7 older result kept", result_o, model(p));
    @(negedge clk); start_i = 1'b0; #1;
    check("R7 no done", done_o, 0);
    @(negedge clk);
    @(negedge clk); #1;
    check("R7 deferred done", done_o, 1);
    check("R7 deferred result", result_o, model(q));
    @(negedge clk); #1;
    check("R5 idle ovf", ovf_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule